// File: doc/BRIEF.md
# Serially Programmed Dual Frequency Divider

This block holds two programmable down-counting dividers: one divides a reference count enable and the other divides the rising edges of a free-running frequency input. Both divide values are written through a three-wire serial port. The port has a shift clock, a data line and a commit strobe, and all three are sampled in the block's system clock domain. A word is made of fourteen divide bits followed by one routing bit. On the commit strobe, the routing bit decides which of the two divide latches receives the word.

Loading the shift register leaves both dividers untouched. A committed value also leaves the running count alone, and it takes effect only at the counter's next terminal count. Each divider emits a one-cycle tick every N counted events. This suits the divider front end of a frequency synthesizer, where the two ticks go to a phase comparator.

Top module: `serial_dual_divider`

## Requirements
- R1: After reset both ticks are low and both divide latches hold all ones. With `refEn` held high, the first reference tick comes 16383 cycles after reset. The shift register resets to zero, so a commit with no prior shifting writes 0 into the feedback latch.
- R2: Each rising edge of `serClk`, after synchronization, shifts the synchronized `serData` into the shift register. A word is 15 bits: the 14 divide bits go first, most significant first, and the routing bit goes last.
- R3: A routing bit of 1 sends the word to the reference latch and a routing bit of 0 sends it to the feedback latch. The latch that is not selected keeps its value.
- R4: The selected latch takes the shift register word while the synchronized `serLatch` is high. Shifting while `serLatch` is low changes neither divider.
- R5: A latch write does not disturb a running count. The new value is loaded at the next terminal count and governs the periods that follow.
- R6: The reference divider counts the cycles in which `refEn` is high and raises `refTick` once every N such cycles.
- R7: The feedback divider counts synchronized rising edges of `fbIn` and raises `fbTick` once every N edges.
- R8: A divide value of 0 or 1 produces a tick on every counted event.
- R9: Each tick lasts a single cycle and only follows a counted event. `refTick` is never high unless `refEn` was high in the cycle before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| serClk | input | 1 | Serial shift clock, asynchronous |
| serData | input | 1 | Serial data, asynchronous |
| serLatch | input | 1 | Commit strobe, active high, asynchronous |
| refEn | input | 1 | Reference count enable, synchronous to clk |
| fbIn | input | 1 | Frequency input to be divided, asynchronous |
| refTick | output | 1 | One-cycle reference divider output |
| fbTick | output | 1 | One-cycle feedback divider output |

## Verification
The assertions assume the serial port never raises the shift clock while the commit strobe is high. They also assume that each serial level is held for several system clocks, so the synchronized data is already settled when its synchronized clock edge arrives. The stimulus holds every serial level for three cycles and keeps the shift clock low around each commit pulse. The frequency input toggles every two cycles, so synchronized edges are always at least two cycles apart.

// File: rtl/sdd_pkg.sv
package sdd_pkg;
  localparam int NUM_CH = 2;
  localparam int REF_CH = 0;
  localparam int FB_CH  = 1;

  typedef struct packed {
    logic shift;
    logic bitIn;
    logic commitRef;
    logic commitFb;
    logic refStep;
    logic fbStep;
  } sdd_strobes_t;
endpackage

// File: rtl/sdd_ctrl.sv
module sdd_ctrl
  import sdd_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         serClk,
  input  logic         serData,
  input  logic         serLatch,
  input  logic         refEn,
  input  logic         fbIn,
  input  logic         ctrlBit,
  output sdd_strobes_t strobes
);
  localparam int NIN = 4;
  localparam int I_CLK = 0;
  localparam int I_DAT = 1;
  localparam int I_LAT = 2;
  localparam int I_FB  = 3;

  logic [NIN-1:0] rawIn;
  logic [SYNC_STAGES-1:0][NIN-1:0] syncStage;
  logic [NIN-1:0] syncOut;
  logic clkPrev, fbPrev;

  assign rawIn   = {fbIn, serLatch, serData, serClk};
  assign syncOut = syncStage[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncStage <= '0;
      clkPrev   <= 1'b0;
      fbPrev    <= 1'b0;
    end else begin
      syncStage[0] <= rawIn;
      for (int s = 1; s < SYNC_STAGES; s++) syncStage[s] <= syncStage[s-1];
      clkPrev <= syncOut[I_CLK];
      fbPrev  <= syncOut[I_FB];
    end
  end

  always_comb begin
    strobes.shift     = syncOut[I_CLK] & ~clkPrev;
    strobes.bitIn     = syncOut[I_DAT];
    strobes.commitRef = syncOut[I_LAT] & ctrlBit;
    strobes.commitFb  = syncOut[I_LAT] & ~ctrlBit;
    strobes.refStep   = refEn;
    strobes.fbStep    = syncOut[I_FB] & ~fbPrev;
  end
endmodule

// File: rtl/sdd_divcounter.sv
module sdd_divcounter #(
  parameter int WIDTH = 14
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] loadVal,
  input  logic             step,
  output logic             tick
);
  logic [WIDTH-1:0] count;

  // Terminal count at 1 or below: a load of 0 or 1 ticks on every step.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      count <= '1;
      tick  <= 1'b0;
    end else begin
      tick <= 1'b0;
      if (step) begin
        if (count <= WIDTH'(1)) begin
          count <= loadVal;
          tick  <= 1'b1;
        end else begin
          count <= count - WIDTH'(1);
        end
      end
    end
  end
endmodule

// File: rtl/sdd_datapath.sv
module sdd_datapath
  import sdd_pkg::*;
#(
  parameter int WIDTH = 14
) (
  input  logic         clk,
  input  logic         rstN,
  input  sdd_strobes_t strobes,
  output logic         ctrlBit,
  output logic         refTick,
  output logic         fbTick
);
  localparam int SR_BITS = WIDTH + 1;

  logic [SR_BITS-1:0] shiftReg;
  logic [WIDTH-1:0]   refLatch, fbLatch;
  logic [WIDTH-1:0]   loadVals [NUM_CH];
  logic [NUM_CH-1:0]  stepVec, tickVec;

  assign ctrlBit = shiftReg[0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
      refLatch <= '1;
      fbLatch  <= '1;
    end else begin
      if (strobes.shift)     shiftReg <= {shiftReg[SR_BITS-2:0], strobes.bitIn};
      if (strobes.commitRef) refLatch <= shiftReg[SR_BITS-1:1];
      if (strobes.commitFb)  fbLatch  <= shiftReg[SR_BITS-1:1];
    end
  end

  assign loadVals[REF_CH] = refLatch;
  assign loadVals[FB_CH]  = fbLatch;
  assign stepVec[REF_CH]  = strobes.refStep;
  assign stepVec[FB_CH]   = strobes.fbStep;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_div
    sdd_divcounter #(.WIDTH(WIDTH)) u_cnt (
      .clk    (clk),
      .rstN   (rstN),
      .loadVal(loadVals[ch]),
      .step   (stepVec[ch]),
      .tick   (tickVec[ch])
    );
  end

  assign refTick = tickVec[REF_CH];
  assign fbTick  = tickVec[FB_CH];
endmodule

// File: rtl/serial_dual_divider.sv
module serial_dual_divider
  import sdd_pkg::*;
#(
  parameter int WIDTH       = 14,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic serClk,
  input  logic serData,
  input  logic serLatch,
  input  logic refEn,
  input  logic fbIn,
  output logic refTick,
  output logic fbTick
);
  sdd_strobes_t strobes;
  logic ctrlBit;

  sdd_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .serClk(serClk), .serData(serData),
    .serLatch(serLatch), .refEn(refEn), .fbIn(fbIn),
    .ctrlBit(ctrlBit), .strobes(strobes)
  );

  sdd_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .ctrlBit(ctrlBit), .refTick(refTick), .fbTick(fbTick)
  );
endmodule

// File: rtl/sdd_checker.sv
module sdd_checker (
  input logic clk,
  input logic rstN,
  input logic refEn,
  input logic refTick,
  input logic fbTick,
  input logic shiftStb,
  input logic commitStb
);
  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (!refTick && !fbTick));

  p_no_shift_in_commit_r4: assert property (@(posedge clk) disable iff (!rstN)
    commitStb |-> !shiftStb);

  p_ref_tick_follows_en_r9: assert property (@(posedge clk) disable iff (!rstN)
    refTick |-> $past(refEn));

  p_fb_tick_single_r9: assert property (@(posedge clk) disable iff (!rstN)
    fbTick |=> !fbTick);
endmodule

bind serial_dual_divider sdd_checker u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .refEn    (refEn),
  .refTick  (refTick),
  .fbTick   (fbTick),
  .shiftStb (strobes.shift),
  .commitStb(strobes.commitRef | strobes.commitFb)
);

// File: tb/sim_serial_dual_divider.sv
`timescale 1ns/1ps
module sim_serial_dual_divider;
  typedef struct {
    int    period;
    string tag;
  } expItem_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic serClk = 1'b0, serData = 1'b0, serLatch = 1'b0;
  logic refEn = 1'b1;
  logic fbIn = 1'b0;
  logic refTick, fbTick;

  int checks = 0, errors = 0;
  int cyc = 0, lastRef = 0, lastFb = 0;
  int refCount = 0, fbCount = 0;
  bit fbRun = 1'b0;
  expItem_t refQ[$];
  expItem_t fbQ[$];

  always #10 clk = ~clk;

  serial_dual_divider u0 (
    .clk(clk), .rstN(rstN), .serClk(serClk), .serData(serData),
    .serLatch(serLatch), .refEn(refEn), .fbIn(fbIn),
    .refTick(refTick), .fbTick(fbTick)
  );

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic pushRef(int period, string tag, int n);
    for (int i = 0; i < n; i++) refQ.push_back('{period, tag});
  endtask

  task automatic pushFb(int period, string tag, int n);
    for (int i = 0; i < n; i++) fbQ.push_back('{period, tag});
  endtask

  task automatic serialBit(bit b);
    serData = b;
    repeat (3) @(negedge clk);
    serClk = 1'b1;
    repeat (3) @(negedge clk);
    serClk = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  // R2: 14 divide bits MSB first, routing bit last
  task automatic loadWord(bit route, int val);
    for (int i = 13; i >= 0; i--) serialBit(val[i]);
    serialBit(route);
  endtask

  task automatic commit();
    serLatch = 1'b1;
    repeat (4) @(negedge clk);
    serLatch = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic waitRef(int n);
    int target;
    target = refCount + n;
    wait (refCount >= target);
  endtask

  task automatic waitFb(int n);
    int target;
    target = fbCount + n;
    wait (fbCount >= target);
  endtask

  // frequency input: one rising edge every 4 cycles
  initial begin
    wait (fbRun);
    forever begin
      fbIn = 1'b0;
      repeat (2) @(negedge clk);
      fbIn = 1'b1;
      repeat (2) @(negedge clk);
    end
  end

  // monitor: measures tick spacing and compares with the queued expectations
  always @(negedge clk) begin
    if (rstN) begin
      cyc++;
      if (refTick) begin
        refCount++;
        if (refQ.size() > 0) begin
          expItem_t it;
          it = refQ.pop_front();
          check((cyc - lastRef) == it.period, it.tag, cyc - lastRef, it.period);
        end
        lastRef = cyc;
      end
      if (fbTick) begin
        fbCount++;
        if (fbQ.size() > 0) begin
          expItem_t it;
          it = fbQ.pop_front();
          check((cyc - lastFb) == it.period, it.tag, cyc - lastFb, it.period);
        end
        lastFb = cyc;
      end
    end
  end

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R1..: actual=timeout expected=done");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(refTick == 1'b0, "R1 refTick in reset", refTick, 0);
    check(fbTick == 1'b0, "R1 fbTick in reset", fbTick, 0);
    // R1: reference latch resets to all ones -> first tick 16383 cycles out
    // R5: the value committed below must not shorten that running count
    pushRef(16383, "R1/R5 first ref period", 1);
    #1 rstN = 1'b1;
    fbRun = 1'b1;
    // R1: cleared shift register, routing bit 0 -> feedback latch gets 0
    commit();
    // R3: routing bit 1 -> reference latch
    loadWord(1'b1, 5);
    commit();
    waitRef(1);
    check(refQ.size() == 0, "R1 first ref tick consumed", refQ.size(), 0);
    pushRef(5, "R6 ref divide by 5", 3);
    wait (refQ.size() == 0);
    // R4: shifting a new word without commit has no effect
    loadWord(1'b1, 9);
    pushRef(5, "R4 uncommitted word ignored", 2);
    wait (refQ.size() == 0);
    commit();
    waitRef(2);
    pushRef(9, "R2/R4 committed word 9 MSB first", 2);
    wait (refQ.size() == 0);
    // R8: 0 and 1 both divide by one
    loadWord(1'b1, 0);
    commit();
    waitRef(2);
    pushRef(1, "R8 divide value 0", 3);
    wait (refQ.size() == 0);
    loadWord(1'b1, 1);
    commit();
    waitRef(2);
    pushRef(1, "R8 divide value 1", 3);
    wait (refQ.size() == 0);
    loadWord(1'b1, 2);
    commit();
    waitRef(2);
    pushRef(2, "R6 divide by 2", 2);
    wait (refQ.size() == 0);
    // feedback divider: drains its all-ones reset count, then divides by 1
    waitFb(1);
    pushFb(4, "R7/R8 fb latch 0 divides by one", 3);
    wait (fbQ.size() == 0);
    // R3: routing bit 0 writes the feedback latch only
    loadWord(1'b0, 3);
    commit();
    waitFb(2);
    pushFb(12, "R7 fb divide by 3", 2);
    waitRef(1);
    pushRef(2, "R3 ref unchanged by fb commit", 3);
    wait (fbQ.size() == 0 && refQ.size() == 0);
    // R9: no reference tick without enable
    refEn = 1'b0;
    @(negedge clk);
    begin
      int seen;
      seen = 0;
      for (int i = 0; i < 10; i++) begin
        @(negedge clk);
        if (refTick) seen++;
      end
      check(seen == 0, "R9 no refTick without refEn", seen, 0);
    end
    refEn = 1'b1;
    repeat (5) @(negedge clk);
    finishRun();
  end
endmodule